// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sits beside a small processor core and decides which clocks run. In normal operation the core, its peripherals and the oscillator all run. A one-cycle software write can put the core into Idle, where only the core clock stops, or into Power-down, where the oscillator itself is switched off. The block also drives the levels that the chip's pins are forced to while the core sleeps.

Idle ends on any enabled interrupt, and the core then resumes at that interrupt's service routine. It also ends on a hardware reset, which reinitialises the special function registers. Power-down can only be left by a hardware reset or by a qualified external interrupt pin. An external pin qualifies when the wake-up enable bit is set, the pin is enabled and the pin is set to level trigger. Wake-up from Power-down takes two steps. A low level on a qualifying pin restarts the oscillator. The exit completes only after a stabilisation counter has expired and the pin has gone back high. After that exit the interrupt is serviced and execution continues with the stored state intact.

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst_n` is released the block is in run: `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, `sfr_reset` and `isr_resume` are 0, and `pin_hold` is 0.
- R2: A one-cycle `req_idle` pulse in run gives `cpu_clk_en`=0 with `per_clk_en`=1 and `osc_en`=1 from the next cycle.
- R3: In Idle, any set bit of `irq_pend` returns the block to run on the next cycle with `cpu_clk_en`=1 and a one-cycle `isr_resume` pulse.
- R4: A one-cycle `req_pdown` pulse in run clears all three enables from the next cycle. If `req_idle` and `req_pdown` arrive together, Power-down is entered.
- R5: In Power-down, a low level on `ext_pin_n[i]` raises `osc_en` on the next cycle only when `wake_en`=1, `ext_en[i]`=1 and `ext_edge[i]`=0 (0 means level trigger). In every other combination the pin is ignored and all enables stay 0.
- R6: Once `osc_en` rises, `cpu_clk_en` stays 0 for at least `SETTLE_CYCLES`+1 cycles. If the exit condition is already met, run is entered exactly `SETTLE_CYCLES`+1 cycles after `osc_en` rises.
- R7: An interrupt wake-up completes only when no qualifying pin is low. It then gives one `isr_resume` pulse and no `sfr_reset`.
- R8: A one-cycle `hw_reset` in run or Idle gives run and a one-cycle `sfr_reset` on the next cycle, with no `isr_resume`. In Power-down it restarts the oscillator, and after stabilisation it gives run with one `sfr_reset` pulse.
- R9: `pin_hold` is 1 in Idle and in Power-down, including warm-up. In Idle `ale_lvl`=1, `psen_lvl`=1 and `pwm_lvl`=1. In Power-down `ale_lvl`=0, `psen_lvl`=0 and `pwm_lvl`=1. In run all four are 0.
- R10: With `ext_mem`=1, `p0_float` is 1 in Idle and in Power-down, and `p2_addr` is 1 only in Idle. With `ext_mem`=0 both are 0.
- R11: `req_idle` and `req_pdown` have no effect outside run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_reset | input | 1 | Hardware reset request from the pin |
| req_idle | input | 1 | One-cycle software write: enter Idle |
| req_pdown | input | 1 | One-cycle software write: enter Power-down |
| wake_en | input | 1 | Allows interrupt wake-up from Power-down |
| irq_pend | input | N_IRQ | Pending, enabled interrupt lines |
| ext_pin_n | input | N_EXT | External interrupt pin levels, active low |
| ext_en | input | N_EXT | External interrupt enables |
| ext_edge | input | N_EXT | Trigger type per pin, 1 = edge, 0 = level |
| ext_mem | input | 1 | Core is executing from external memory |
| cpu_clk_en | output | 1 | Core clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| osc_en | output | 1 | Oscillator enable |
| sfr_reset | output | 1 | One-cycle strobe: reinitialise the special function registers |
| isr_resume | output | 1 | One-cycle strobe: resume at the interrupt service routine |
| pin_hold | output | 1 | Pin overrides active |
| ale_lvl | output | 1 | Forced address-latch strobe level |
| psen_lvl | output | 1 | Forced program-store strobe level |
| pwm_lvl | output | 1 | Forced PWM output level |
| p0_float | output | 1 | Float the multiplexed address/data port |
| p2_addr | output | 1 | High-address port keeps driving the address |

## Verification
The hardest case to reach is the middle of a two-step wake-up. The oscillator is already running and the counter has expired, but the qualifying pin is still held low, so the core must stay gated. The stimulus sweeps pin, enable, trigger type and wake-up enable through all sixteen combinations. In each qualifying combination it holds the pin low well past the count before releasing it. It also runs a separate case with a one-cycle low pulse, which measures the exact count. Non-qualifying combinations are then left by a hardware reset, which also covers the reset exit from Power-down.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power mode sequencer.
// Assumes: one clock domain; the states are encoded in two bits.
package lpm_pkg;
    typedef enum logic [1:0] {
        LPM_RUN   = 2'd0,
        LPM_IDLE  = 2'd1,
        LPM_PDOWN = 2'd2,
        LPM_WARM  = 2'd3
    } lpm_state_e;

    typedef enum logic {
        CAUSE_WAKE  = 1'b0,
        CAUSE_RESET = 1'b1
    } lpm_cause_e;
endpackage

// File: rtl/lpm_wake_detect.sv
// Qualifies the external interrupt pins for Power-down wake-up.
// A pin qualifies when wake-up is enabled, the pin is enabled and the pin
// is level-triggered. wake_req is 1 while any qualifying pin is low.
// Assumes: pins are already synchronised to clk.
module lpm_wake_detect #(
    parameter int N_EXT = 2
) (
    input  logic             wake_en,
    input  logic [N_EXT-1:0] ext_pin_n,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [N_EXT-1:0] ext_edge,
    output logic             wake_req,
    output logic             wake_released
);
    logic [N_EXT-1:0] pin_low_qual;

    for (genvar i = 0; i < N_EXT; i++) begin : g_pin
        // one pin: qualified and currently low
        assign pin_low_qual[i] = wake_en & ext_en[i] & ~ext_edge[i] & ~ext_pin_n[i];
    end

    // summarise all pins
    assign wake_req      = |pin_low_qual;
    assign wake_released = ~wake_req;
endmodule

// File: rtl/lpm_settle_timer.sv
// Oscillator stabilisation counter. It counts while run is 1 and holds at
// LIMIT. It clears whenever run is 0.
// Assumes: run rises in the first cycle the oscillator is enabled again.
module lpm_settle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(LIMIT));

    // count up while the oscillator warms, saturating at LIMIT
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!done)     cnt <= cnt + 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT)); // R6
endmodule

// File: rtl/lpm_pin_override.sv
// Decodes the pin levels forced while the core sleeps.
// Assumes: state comes straight from the sequencer's state register.
module lpm_pin_override
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lpm_state_e state,
    input  logic       ext_mem,
    output logic       pin_hold,
    output logic       ale_lvl,
    output logic       psen_lvl,
    output logic       pwm_lvl,
    output logic       p0_float,
    output logic       p2_addr
);
    logic in_idle, in_pd;

    // classify the state
    always_comb begin
        in_idle = (state == LPM_IDLE);
        in_pd   = (state == LPM_PDOWN) || (state == LPM_WARM);
    end

    // forced levels per mode
    always_comb begin
        pin_hold = in_idle | in_pd;
        ale_lvl  = in_idle;
        psen_lvl = in_idle;
        pwm_lvl  = in_idle | in_pd;
        p0_float = ext_mem & (in_idle | in_pd);
        p2_addr  = ext_mem & in_idle;
    end

    AST_P2_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        p2_addr |-> (psen_lvl && p0_float)); // R10
endmodule

// File: rtl/lpm_mode_fsm.sv
// Mode sequencer: run, Idle, Power-down and oscillator warm-up.
// Hardware reset has the highest priority, and Power-down wins over Idle.
// The exit strobes are registered, so each is high in the first run cycle.
// Assumes: req_idle and req_pdown are one-cycle write strobes.
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_reset,
    input  logic       req_idle,
    input  logic       req_pdown,
    input  logic       irq_any,
    input  logic       wake_req,
    input  logic       wake_released,
    input  logic       tmr_done,
    output lpm_state_e state,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       sfr_reset,
    output logic       isr_resume
);
    lpm_state_e nxt;
    lpm_cause_e cause, nxt_cause;
    logic       go_sfr, go_isr;

    // next-state and exit-strobe decision
    always_comb begin
        nxt       = state;
        nxt_cause = cause;
        go_sfr    = 1'b0;
        go_isr    = 1'b0;
        case (state)
            LPM_RUN: begin
                if (hw_reset)       go_sfr = 1'b1;
                else if (req_pdown) nxt = LPM_PDOWN;
                else if (req_idle)  nxt = LPM_IDLE;
            end
            LPM_IDLE: begin
                if (hw_reset) begin
                    nxt = LPM_RUN; go_sfr = 1'b1;
                end else if (irq_any) begin
                    nxt = LPM_RUN; go_isr = 1'b1;
                end
            end
            LPM_PDOWN: begin
                if (hw_reset) begin
                    nxt = LPM_WARM; nxt_cause = CAUSE_RESET;
                end else if (wake_req) begin
                    nxt = LPM_WARM; nxt_cause = CAUSE_WAKE;
                end
            end
            LPM_WARM: begin
                if (hw_reset) nxt_cause = CAUSE_RESET;
                if (tmr_done) begin
                    if (hw_reset || cause == CAUSE_RESET) begin
                        nxt = LPM_RUN; go_sfr = 1'b1;
                    end else if (wake_released) begin
                        nxt = LPM_RUN; go_isr = 1'b1;
                    end
                end
            end
            default: nxt = LPM_RUN;
        endcase
    end

    // state, exit cause and strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= LPM_RUN;
            cause      <= CAUSE_WAKE;
            sfr_reset  <= 1'b0;
            isr_resume <= 1'b0;
        end else begin
            state      <= nxt;
            cause      <= nxt_cause;
            sfr_reset  <= go_sfr;
            isr_resume <= go_isr;
        end
    end

    // clock and oscillator gates from the state
    always_comb begin
        cpu_clk_en = (state == LPM_RUN);
        per_clk_en = (state == LPM_RUN) || (state == LPM_IDLE);
        osc_en     = (state != LPM_PDOWN);
    end

    AST_IDLE_IRQ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LPM_IDLE && irq_any && !hw_reset) |=> (cpu_clk_en && isr_resume)); // R3
    AST_PD_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LPM_PDOWN && !hw_reset && !wake_req) |=> !osc_en); // R5
    AST_SETTLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LPM_WARM && !tmr_done) |=> !cpu_clk_en); // R6
    AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LPM_WARM && cause == CAUSE_WAKE && !hw_reset && !wake_released) |=> !cpu_clk_en); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_reset && isr_resume)); // R8
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LPM_IDLE && !irq_any && !hw_reset) |=> (state == LPM_IDLE)); // R11
endmodule

// File: rtl/lpm_ctrl.sv
// Top of the low-power mode sequencer. It joins wake-pin qualification,
// the stabilisation timer, the mode sequencer and the pin-level decode.
// Assumes: irq_pend carries only interrupts that are already enabled.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_IRQ         = 8,
    parameter int N_EXT         = 2,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_reset,
    input  logic             req_idle,
    input  logic             req_pdown,
    input  logic             wake_en,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_EXT-1:0] ext_pin_n,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [N_EXT-1:0] ext_edge,
    input  logic             ext_mem,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             sfr_reset,
    output logic             isr_resume,
    output logic             pin_hold,
    output logic             ale_lvl,
    output logic             psen_lvl,
    output logic             pwm_lvl,
    output logic             p0_float,
    output logic             p2_addr
);
    lpm_state_e state;
    logic       wake_req, wake_released, tmr_done, irq_any;

    // any enabled interrupt ends Idle
    assign irq_any = |irq_pend;

    lpm_wake_detect #(.N_EXT(N_EXT)) u_wake (
        .wake_en       (wake_en),
        .ext_pin_n     (ext_pin_n),
        .ext_en        (ext_en),
        .ext_edge      (ext_edge),
        .wake_req      (wake_req),
        .wake_released (wake_released)
    );

    lpm_settle_timer #(.LIMIT(SETTLE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == LPM_WARM),
        .done  (tmr_done)
    );

    lpm_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hw_reset      (hw_reset),
        .req_idle      (req_idle),
        .req_pdown     (req_pdown),
        .irq_any       (irq_any),
        .wake_req      (wake_req),
        .wake_released (wake_released),
        .tmr_done      (tmr_done),
        .state         (state),
        .cpu_clk_en    (cpu_clk_en),
        .per_clk_en    (per_clk_en),
        .osc_en        (osc_en),
        .sfr_reset     (sfr_reset),
        .isr_resume    (isr_resume)
    );

    lpm_pin_override u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .ext_mem  (ext_mem),
        .pin_hold (pin_hold),
        .ale_lvl  (ale_lvl),
        .psen_lvl (psen_lvl),
        .pwm_lvl  (pwm_lvl),
        .p0_float (p0_float),
        .p2_addr  (p2_addr)
    );

    AST_OSC_OFF_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!cpu_clk_en && !per_clk_en && pin_hold)); // R4
    AST_RESUME_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        isr_resume |-> (cpu_clk_en && !$past(cpu_clk_en))); // R7
endmodule

// File: tb/tb_lpm_ctrl.sv
// Self-checking bench for lpm_ctrl: sweeps the wake configurations, every
// interrupt line, the pin decode and the reset exits.
module tb_lpm_ctrl;
    localparam int NI = 8;
    localparam int NE = 2;
    localparam int S  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_reset = 1'b0, req_idle = 1'b0, req_pdown = 1'b0, wake_en = 1'b0;
    logic [NI-1:0] irq_pend = '0;
    logic [NE-1:0] ext_pin_n = '1, ext_en = '0, ext_edge = '0;
    logic ext_mem = 1'b0;
    logic cpu_clk_en, per_clk_en, osc_en, sfr_reset, isr_resume;
    logic pin_hold, ale_lvl, psen_lvl, pwm_lvl, p0_float, p2_addr;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #2.5 clk = ~clk;

    lpm_ctrl #(.N_IRQ(NI), .N_EXT(NE), .SETTLE_CYCLES(S)) dut (
        .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .req_idle(req_idle),
        .req_pdown(req_pdown), .wake_en(wake_en), .irq_pend(irq_pend),
        .ext_pin_n(ext_pin_n), .ext_en(ext_en), .ext_edge(ext_edge),
        .ext_mem(ext_mem), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .sfr_reset(sfr_reset), .isr_resume(isr_resume),
        .pin_hold(pin_hold), .ale_lvl(ale_lvl), .psen_lvl(psen_lvl),
        .pwm_lvl(pwm_lvl), .p0_float(p0_float), .p2_addr(p2_addr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // advance one edge, then sample 1 ns later
    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // pack the three enables as {cpu,per,osc}
    function automatic int gates();
        return {29'd0, cpu_clk_en, per_clk_en, osc_en};
    endfunction

    function automatic int pins();
        return {26'd0, pin_hold, ale_lvl, psen_lvl, pwm_lvl, p0_float, p2_addr};
    endfunction

    task automatic enter_pd();
        req_pdown = 1'b1; step(); req_pdown = 1'b0;
        check("R4 pd entry", gates(), 0);
    endtask

    task automatic enter_idle();
        req_idle = 1'b1; step(); req_idle = 1'b0;
        check("R2 idle entry", gates(), 3'b010 | 3'b001);
    endtask

    // leave Power-down by hardware reset and time the warm-up
    task automatic reset_exit_pd(input string req);
        hw_reset = 1'b1; step(); hw_reset = 1'b0;
        check({req, " osc restart"}, osc_en, 1);
        step(S);
        check({req, " gated during settle"}, cpu_clk_en, 0);
        step();
        check({req, " run after settle"}, gates(), 7);
        check({req, " sfr strobe"}, sfr_reset, 1);
        check({req, " no resume"}, isr_resume, 0);
        step();
        check({req, " sfr one cycle"}, sfr_reset, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        step(3);
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 gates", gates(), 7);
        check("R1 strobes", {sfr_reset, isr_resume}, 0);
        check("R1 pins", pins(), 0);

        // R2, R3, R11: each interrupt line ends Idle
        for (int i = 0; i < NI; i++) begin
            enter_idle();
            req_pdown = 1'b1; req_idle = 1'b1; step(); req_pdown = 1'b0; req_idle = 1'b0;
            check("R11 req in idle ignored", gates(), 3);
            irq_pend = NI'(1) << i; step(); irq_pend = '0;
            check("R3 idle exit", gates(), 7);
            check("R3 resume strobe", isr_resume, 1);
            check("R3 no sfr", sfr_reset, 0);
            step();
            check("R3 resume one cycle", isr_resume, 0);
        end

        // R4 priority of Power-down over Idle, R11 in Power-down
        req_idle = 1'b1; req_pdown = 1'b1; step(); req_idle = 1'b0; req_pdown = 1'b0;
        check("R4 pd priority", gates(), 0);
        req_idle = 1'b1; step(); req_idle = 1'b0;
        check("R11 req in pd ignored", gates(), 0);
        reset_exit_pd("R8 pd reset");

        // R9, R10 pin decode in each mode with both memory settings
        for (int m = 0; m < 2; m++) begin
            ext_mem = m[0];
            step();
            check("R9 run pins", pins(), 0);
            enter_idle();
            check("R9 R10 idle pins", pins(), {1'b1, 1'b1, 1'b1, 1'b1, m[0], m[0]});
            irq_pend = 1; step(); irq_pend = '0;
            enter_pd();
            check("R9 R10 pd pins", pins(), {1'b1, 1'b0, 1'b0, 1'b1, m[0], 1'b0});
            reset_exit_pd("R8 pd reset");
        end
        ext_mem = 1'b0;

        // R8 hardware reset from run and from Idle
        hw_reset = 1'b1; step(); hw_reset = 1'b0;
        check("R8 run reset", {cpu_clk_en, sfr_reset, isr_resume}, 3'b110);
        step();
        check("R8 sfr one cycle", sfr_reset, 0);
        enter_idle();
        hw_reset = 1'b1; step(); hw_reset = 1'b0;
        check("R8 idle reset", {cpu_clk_en, sfr_reset, isr_resume}, 3'b110);
        step();

        // R5, R7 sweep: pin x enable x trigger type x wake enable
        for (int c = 0; c < 16; c++) begin
            int pin = c & 1;
            bit en = c[1], edg = c[2], we = c[3];
            bit qual = we & en & ~edg;
            ext_en = en ? NE'(1) << pin : '0;
            ext_edge = edg ? NE'(1) << pin : '0;
            wake_en = we;
            enter_pd();
            ext_pin_n[pin] = 1'b0; step();
            check("R5 wake qualification", osc_en, int'(qual));
            if (qual) begin
                step(S + 4);
                check("R7 held low stays gated", cpu_clk_en, 0);
                check("R9 warm pins", pins(), 6'b100100);
                ext_pin_n[pin] = 1'b1; step();
                check("R7 exit on release", cpu_clk_en, 1);
                check("R7 resume strobe", isr_resume, 1);
                check("R7 no sfr", sfr_reset, 0);
                step();
            end else begin
                step(3);
                check("R5 ignored pin", gates(), 0);
                ext_pin_n[pin] = 1'b1;
                reset_exit_pd("R8 pd reset");
            end
        end

        // R6 exact warm-up length with a short low pulse
        ext_en = 2'b10; ext_edge = 2'b00; wake_en = 1'b1;
        enter_pd();
        ext_pin_n[1] = 1'b0; step(); ext_pin_n[1] = 1'b1;
        check("R6 osc on", osc_en, 1);
        step(S);
        check("R6 gated through settle", cpu_clk_en, 0);
        step();
        check("R6 run at settle+1", cpu_clk_en, 1);
        check("R6 resume strobe", isr_resume, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule